// File: doc/BRIEF.md
# Stochastic Bundle Multiplier

This block multiplies two real numbers in the range [0,1] that are carried in stochastic form. Each number travels as an N-wire bundle, and the chance that any one wire carries a 1 equals the value. A serial stream of bits over time would hold the same information. Here all N bits arrive together, once per clock.

To form the product, the block pairs every wire of operand A with exactly one wire of operand B and takes the AND of each pair. Operand B first passes through a fixed scrambled one-to-one wiring map, which is built when the design is elaborated from a seed parameter using a Fisher–Yates shuffle. Because of this map, matching positions in the two bundles are not paired. This breaks the correlation that a straight wire-by-wire AND would suffer when both bundles come from related sources.

The output bundle is registered, and a valid flag follows it with the same one-cycle delay. A ones-count of the registered output is available for checking. If the two inputs are independent, the output density approximates the product of the two input densities.

Top module: `stoch_mult`

## Requirements
- R1: While `rst_n` is low and after its release, before any input is captured, `out_valid` is 0, `c_bundle` is all zeros and `c_count` is 0.
- R2: `out_valid` equals the value of `in_valid` at the previous rising clock edge.
- R3: When `a_bundle` or `b_bundle` is all zeros at a rising edge, `c_bundle` is all zeros after that edge.
- R4: When both input bundles are all ones at a rising edge, `c_bundle` is all ones after that edge.
- R5: When `b_bundle` is all ones at a rising edge, `c_bundle` after that edge equals the `a_bundle` captured at that edge, bit for bit.
- R6: The pairing is one-to-one. When `a_bundle` is all ones, the number of ones on `c_bundle` after the edge equals the number of ones on the captured `b_bundle`. A `b_bundle` with a single 1 in any of the N positions gives a `c_bundle` with exactly one 1.
- R7: `c_count` always equals the number of ones on `c_bundle`, and is ceil(log2(N+1)) bits wide.
- R8: For independent random bundles with wire densities a and b, the mean of `c_count` over 1000 cycles lies within 1.0 of N·a·b.
- R9: When the same random bundle of density x is applied to both inputs, the mean of `c_count` over 1000 cycles lies within 2.0 of N·x², and not near N·x, which a straight AND would give.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Marks the input bundles as meaningful |
| a_bundle | input | N | Stochastic bundle for operand A |
| b_bundle | input | N | Stochastic bundle for operand B |
| out_valid | output | 1 | `in_valid` delayed by one cycle |
| c_bundle | output | N | Registered product bundle |
| c_count | output | ceil(log2(N+1)) | Number of ones on `c_bundle` |

## Verification
Each result is due one rising edge after its operands are presented. `c_bundle` and `out_valid` change at that edge, and `c_count` settles with them because it is derived from the register with no further delay. The bench changes inputs on the falling edge and reads the outputs 1 ns after the next rising edge, so every sample reflects exactly the operands of the preceding cycle. For the statistical requirements, the per-cycle counts are summed over a block of cycles and the mean is compared with N·a·b, or with N·x² when both inputs are the same bundle. The threshold densities come from a vector table in the bench.

// File: rtl/stoch_mult.sv
module stoch_mult #(
  parameter int          N    = 64,
  parameter logic [31:0] SEED = 32'h2545_F491
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_valid,
  input  logic [N-1:0]               a_bundle,
  input  logic [N-1:0]               b_bundle,
  output logic                       out_valid,
  output logic [N-1:0]               c_bundle,
  output logic [$clog2(N+1)-1:0]     c_count
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;
  localparam int CW = $clog2(N+1);

  function automatic logic [N*IW-1:0] build_map();
    logic [31:0] st;
    int          j;
    int          t;
    int          p[N];
    st = SEED | 32'd1;
    for (int i = 0; i < N; i++) p[i] = i;
    for (int i = N - 1; i > 0; i--) begin
      st = st ^ (st << 13);
      st = st ^ (st >> 17);
      st = st ^ (st << 5);
      j = int'(st % 32'(i + 1));
      t = p[i];
      p[i] = p[j];
      p[j] = t;
    end
    for (int i = 0; i < N; i++) build_map[i*IW +: IW] = IW'(p[i]);
  endfunction

  localparam logic [N*IW-1:0] MAP = build_map();

  logic [N-1:0] b_shuf;
  logic [N-1:0] prod;
  logic [N-1:0] c_q;
  logic         v_q;
  logic [CW-1:0] ones;

  for (genvar i = 0; i < N; i++) begin : g_route
    assign b_shuf[i] = b_bundle[MAP[i*IW +: IW]];
  end

  assign prod = a_bundle & b_shuf;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      c_q <= '0;
      v_q <= 1'b0;
    end else begin
      c_q <= prod;
      v_q <= in_valid;
    end
  end

  always_comb begin
    ones = '0;
    for (int i = 0; i < N; i++) ones = ones + CW'(c_q[i]);
  end

  assign c_bundle  = c_q;
  assign out_valid = v_q;
  assign c_count   = ones;
endmodule

// File: rtl/stoch_mult_chk.sv
module stoch_mult_chk #(
  parameter int N = 64
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   in_valid,
  input logic [N-1:0]           a_bundle,
  input logic [N-1:0]           b_bundle,
  input logic                   out_valid,
  input logic [N-1:0]           c_bundle,
  input logic [$clog2(N+1)-1:0] c_count
);
  p_valid_delay_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n && $past(rst_n) |-> out_valid == $past(in_valid));

  p_zero_in_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (a_bundle == '0 || b_bundle == '0) |=> c_bundle == '0);

  p_all_ones_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (a_bundle == '1 && b_bundle == '1) |=> c_bundle == '1);

  p_pass_a_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (b_bundle == '1) |=> c_bundle == $past(a_bundle));

  p_bijection_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (a_bundle == '1) |=> c_count == $countones($past(b_bundle)));

  p_count_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (c_count == 0) == (c_bundle == '0));
endmodule

bind stoch_mult stoch_mult_chk #(.N(N)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
  .a_bundle(a_bundle), .b_bundle(b_bundle),
  .out_valid(out_valid), .c_bundle(c_bundle), .c_count(c_count)
);

// File: tb/stoch_mult_test.sv
`timescale 1ns/1ps
module stoch_mult_test;
  localparam int N  = 64;
  localparam int CW = $clog2(N+1);
  localparam int RUN = 1000;
  localparam int NV = 5;
  localparam int TA [NV] = '{128, 64, 192, 32, 240};
  localparam int TB [NV] = '{128, 192, 192, 224, 16};

  logic clk = 0;
  logic rst_n = 0;
  logic in_valid = 0;
  logic [N-1:0] a = '0, b = '0;
  logic out_valid;
  logic [N-1:0] c;
  logic [CW-1:0] cnt;
  logic [31:0] rng = 32'h1357_9BDF;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  stoch_mult #(.N(N)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .a_bundle(a), .b_bundle(b),
    .out_valid(out_valid), .c_bundle(c), .c_count(cnt)
  );

  task automatic chk(input string req, input logic ok, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input logic [N-1:0] av, input logic [N-1:0] bv, input logic v);
    @(negedge clk);
    a = av; b = bv; in_valid = v;
    @(posedge clk);
    #1;
  endtask

  function automatic logic [N-1:0] gen(input int thr);
    logic [N-1:0] r;
    for (int i = 0; i < N; i++) begin
      rng = rng ^ (rng << 13);
      rng = rng ^ (rng >> 17);
      rng = rng ^ (rng << 5);
      r[i] = (int'(rng[7:0]) < thr);
    end
    return r;
  endfunction

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [N-1:0] ra, rb;
    real sum, mean, expv;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset valid", out_valid == 0, out_valid, 0);
    chk("R1 reset bundle", c == '0, $countones(c), 0);
    chk("R1 reset count", cnt == 0, cnt, 0);
    @(negedge clk); rst_n = 1;
    @(posedge clk); #1;
    chk("R1 after release", c == '0 && out_valid == 0, cnt, 0);

    // R8: vector table of independent densities
    for (int v = 0; v < NV; v++) begin
      sum = 0.0;
      for (int k = 0; k < RUN; k++) begin
        ra = gen(TA[v]); rb = gen(TB[v]);
        cyc(ra, rb, 1'b1);
        sum += real'(cnt);
        if (cnt != CW'($countones(c))) chk("R7 count", 1'b0, cnt, $countones(c));
      end
      checks++;
      mean = sum / RUN;
      expv = real'(N) * real'(TA[v]) * real'(TB[v]) / 65536.0;
      if (mean > expv + 1.0 || mean < expv - 1.0) begin
        errors++;
        $display("FAIL R8 vector %0d actual=%f expected=%f", v, mean, expv);
      end
    end

    // R9: same bundle on both operands
    sum = 0.0;
    for (int k = 0; k < RUN; k++) begin
      ra = gen(128);
      cyc(ra, ra, 1'b1);
      sum += real'(cnt);
    end
    checks++;
    mean = sum / RUN;
    if (mean > 18.0 || mean < 14.0) begin
      errors++;
      $display("FAIL R9 actual=%f expected=16.0", mean);
    end

    // R2: valid delay
    cyc(gen(128), gen(128), 1'b0);
    chk("R2 valid low", out_valid == 0, out_valid, 0);
    cyc(gen(128), gen(128), 1'b1);
    chk("R2 valid high", out_valid == 1, out_valid, 1);

    // R3: zero operand
    cyc('0, gen(200), 1'b1);
    chk("R3 a zero", c == '0, $countones(c), 0);
    cyc(gen(200), '0, 1'b1);
    chk("R3 b zero", c == '0 && cnt == 0, cnt, 0);

    // R4: both all ones
    cyc('1, '1, 1'b1);
    chk("R4 all ones", c == '1, $countones(c), N);
    chk("R7 full count", cnt == CW'(N), cnt, N);

    // R5: b all ones passes a
    ra = gen(100);
    cyc(ra, '1, 1'b1);
    chk("R5 pass a", c == ra, $countones(c), $countones(ra));
    ra = gen(30);
    cyc(ra, '1, 1'b1);
    chk("R5 pass a sparse", c == ra, $countones(c), $countones(ra));

    // R6: a all ones keeps the count of b
    rb = gen(90);
    cyc('1, rb, 1'b1);
    chk("R6 count kept", cnt == CW'($countones(rb)), cnt, $countones(rb));
    for (int i = 0; i < N; i++) begin
      rb = '0; rb[i] = 1'b1;
      cyc('1, rb, 1'b1);
      chk("R6 one-hot", $countones(c) == 1 && cnt == 1, $countones(c), 1);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule